// File: doc/BRIEF.md
# Four-Mode Barrel Shift Unit

This unit executes the shift group of a 32-bit load-store processor. Each cycle it receives the instruction word, the operand register value, and the value of a second register that can supply a shift amount. It decodes the opcode, works out the shift amount, applies one of four shift kinds in a single combinational pass, and registers the result together with the destination register index and a write strobe. The register file consumes these one cycle after the instruction is presented.

The amount comes from the instruction's low five bits when they are nonzero. If those bits are zero, it comes from the low five bits of the second register. No separate flag selects between the two sources. The four kinds are zero-fill right, sign-fill right, zero-fill left, and rotate left.

Top module: `barrel_shift_unit`

## Requirements
- R1: When instruction bits 4..0 are nonzero, they are the shift amount and the count register is ignored.
- R2: When instruction bits 4..0 are zero, the amount is bits 4..0 of the count register; its higher bits are ignored, so values of 32 or more wrap modulo 32.
- R3: Opcode 26 (instruction bits 31..27) shifts the operand right by n and fills the vacated top n bits with zeros.
- R4: Opcode 27 shifts right by n and fills the top n bits with copies of operand bit 31; for example, 0x97EAEC16 by 13 gives 0xFFFCBF57.
- R5: Opcode 28 shifts left by n and fills the low n bits with zeros.
- R6: Opcode 29 rotates left by n; bits leaving bit 31 re-enter at bit 0, and the number of one bits is preserved.
- R7: An effective amount of 0 returns the operand unchanged in all four modes.
- R8: For any opcode outside 26..29, the write strobe is low and the result output is zero.
- R9: Result, strobe and destination index (instruction bits 26..22) appear on the outputs one clock edge after the inputs, and a new instruction can be accepted every cycle.
- R10: While reset is asserted (rst_n low), result, destination and strobe are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Operand to be shifted |
| amt_val | input | 32 | Register value; low 5 bits give the fallback shift amount |
| res_o | output | 32 | Registered shift result |
| dst_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered write strobe for the destination |

## Verification
Two sources can supply the shift amount in the same cycle: the immediate field and the count register. The bench provokes this by giving a nonzero field together with a count register that holds a different, nonzero amount. The result must follow the field alone. It must follow the register only when the field is zero, and for that case the bench loads register values above 31 so the modulo-32 wrap is also checked. Instructions are issued back to back, so each output is compared in the cycle after its own inputs while the next instruction is already being driven.

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  instr,
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] amt_val,
  output logic [W-1:0] res_o,
  output logic [4:0]   dst_o,
  output logic         wr_en_o
);
  localparam int CW = $clog2(W);
  localparam logic [4:0] OP_SRL = 5'd26;
  localparam logic [4:0] OP_SRA = 5'd27;
  localparam logic [4:0] OP_SLL = 5'd28;
  localparam logic [4:0] OP_ROL = 5'd29;

  logic [4:0]    opc;
  logic [CW-1:0] imm_amt, n;
  logic          is_shift;
  logic [2*W-1:0] dbl;
  logic [W-1:0]  shv;

  assign opc      = instr[31:27];
  assign imm_amt  = instr[CW-1:0];
  assign n        = (imm_amt != '0) ? imm_amt : amt_val[CW-1:0];
  assign is_shift = (opc >= OP_SRL) && (opc <= OP_ROL);
  assign dbl      = {src_val, src_val} << n;

  always_comb begin
    case (opc)
      OP_SRL:  shv = src_val >> n;
      OP_SRA:  shv = $unsigned($signed(src_val) >>> n);
      OP_SLL:  shv = src_val << n;
      OP_ROL:  shv = dbl[2*W-1:W];
      default: shv = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      dst_o   <= '0;
      wr_en_o <= 1'b0;
    end else begin
      res_o   <= shv;
      dst_o   <= instr[26:22];
      wr_en_o <= is_shift;
    end
  end

  AST_WE_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:27] inside {[5'd26:5'd29]}) |=> wr_en_o); // R9
  AST_NO_WE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr[31:27] inside {[5'd26:5'd29]}) |=> (!wr_en_o && res_o == '0)); // R8
  AST_DST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dst_o == $past(instr[26:22])); // R9
  AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((instr[31:27] inside {[5'd26:5'd29]}) && instr[CW-1:0] == '0 && amt_val[CW-1:0] == '0)
      |=> res_o == $past(src_val)); // R7
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:27] == 5'd29) |=> $countones(res_o) == $countones($past(src_val))); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (res_o == '0 && dst_o == '0 && !wr_en_o)); // R10
endmodule

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, src_val = '0, amt_val = '0;
  logic [31:0] res_o;
  logic [4:0]  dst_o;
  logic        wr_en_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  barrel_shift_unit dut (.clk(clk), .rst_n(rst_n), .instr(instr), .src_val(src_val),
    .amt_val(amt_val), .res_o(res_o), .dst_o(dst_o), .wr_en_o(wr_en_o));

  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] x, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (op)
        5'd26: r[i] = (i + n < 32) ? x[i + n] : 1'b0;
        5'd27: r[i] = (i + n < 32) ? x[i + n] : x[31];
        5'd28: r[i] = (i >= n) ? x[i - n] : 1'b0;
        5'd29: r[i] = x[(i - n + 32) % 32];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one instruction, check its outputs one edge later.
  task automatic run_op(input string tag, input logic [4:0] op, input logic [4:0] ra,
                        input logic [4:0] fld, input logic [31:0] x, input logic [31:0] rc,
                        input int n_exp);
    logic sh;
    sh = (op >= 5'd26 && op <= 5'd29);
    instr = {op, ra, 5'd3, 5'd7, 7'h55, fld};
    src_val = x;
    amt_val = rc;
    @(posedge clk);
    @(negedge clk);
    chk(tag, res_o, model(op, x, n_exp));
    chk({tag, " we"}, {31'd0, wr_en_o}, {31'd0, sh});
    if (sh) chk({tag, " dst R9"}, {27'd0, dst_o}, {27'd0, ra});
  endtask

  task automatic t_reset;
    chk("R10 res", res_o, 32'd0);
    chk("R10 dst", {27'd0, dst_o}, 32'd0);
    chk("R10 we", {31'd0, wr_en_o}, 32'd0);
  endtask

  task automatic t_modes;
    run_op("R3 srl", 5'd26, 5'd4, 5'd8, 32'hF0F0_1234, 32'd0, 8);
    run_op("R4 sra example", 5'd27, 5'd1, 5'd13, 32'h97EA_EC16, 32'd0, 13);
    chk("R4 literal", res_o, 32'hFFFC_BF57);
    run_op("R4 sra positive", 5'd27, 5'd2, 5'd4, 32'h7000_0001, 32'd0, 4);
    run_op("R5 sll", 5'd28, 5'd9, 5'd31, 32'h0000_0003, 32'd0, 31);
    run_op("R6 rol", 5'd29, 5'd30, 5'd12, 32'h8765_4321, 32'd0, 12);
    run_op("R6 rol by 31", 5'd29, 5'd31, 5'd31, 32'h0000_0001, 32'd0, 31);
  endtask

  task automatic t_count_source;
    run_op("R1 field wins", 5'd26, 5'd5, 5'd3, 32'hFFFF_0000, 32'd17, 3);
    run_op("R2 from reg", 5'd28, 5'd6, 5'd0, 32'h0000_00FF, 32'd6, 6);
    run_op("R2 wrap 37", 5'd26, 5'd7, 5'd0, 32'h8000_0000, 32'd37, 5);
    run_op("R2 wrap 64", 5'd29, 5'd8, 5'd0, 32'hDEAD_BEEF, 32'd64, 0);
  endtask

  task automatic t_zero_amt;
    for (int op = 26; op <= 29; op++)
      run_op("R7 zero count", 5'(op), 5'd11, 5'd0, 32'hA5C3_0F81, 32'hFFFF_FFE0, 0);
  endtask

  task automatic t_other_ops;
    run_op("R8 op 12", 5'd12, 5'd3, 5'd4, 32'h1234_5678, 32'd1, 0);
    run_op("R8 op 25", 5'd25, 5'd3, 5'd4, 32'h1234_5678, 32'd1, 0);
    run_op("R8 op 30", 5'd30, 5'd3, 5'd4, 32'h1234_5678, 32'd1, 0);
    run_op("R9 back to back", 5'd27, 5'd17, 5'd1, 32'h8000_0000, 32'd0, 1);
  endtask

  initial begin
    #1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_modes();
    t_count_source();
    t_zero_amt();
    t_other_ops();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule